// File: doc/BRIEF.md
# Flash Chip-Erase Command Interpreter

This block sits on the device side of a byte-wide flash memory. It sees every write cycle as an address and a data byte and follows a six-cycle chip-erase command. Two unlock-coded cycles come first, then an erase-setup byte, then two more unlock-coded cycles, and last a confirm byte. Any cycle that does not match the expected code drops the interpreter back to read-array mode, and the cycle is not counted.

A complete command starts a modelled erase controller, which runs off counters. The controller first programs every location of a small register array to 00h on its own, one location every `PROG_CYCLES` clocks. It then runs erase iterations of `ERASE_CYCLES` clocks each. After each iteration a verify step either fills the array with FFh or, when the `force_fail` test input is high, counts a failed iteration. After `MAX_ITER` failed iterations the controller gives up and raises the failure flag.

While the erase runs, reads return a status byte instead of array data, and write cycles are ignored. A held failure status is cleared by any write cycle.

Top module: `chip_erase_ctrl`

## Requirements
- R1: After reset `rd_data` is 00h, and a read of location i (address bits below log2(DEPTH)) returns the preset byte (i*59+17) mod 256.
- R2: The write cycles AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h, in this order, start the erase. A read accepted on any clock after the sixth write returns status with bit 7 = 0 until the erase ends.
- R3: A write whose address or data differs from the next expected cycle aborts the sequence. That cycle is not counted, no erase starts, and reads keep returning array data.
- R4: A sixth cycle that carries any byte other than 10h (for example 30h) aborts without erasing.
- R5: A passing erase keeps status bit 7 at 0 for exactly DEPTH*PROG_CYCLES + ERASE_CYCLES consecutive per-clock reads. A failing erase keeps it at 0 for DEPTH*PROG_CYCLES + MAX_ITER*ERASE_CYCLES reads.
- R6: Status bit 6 inverts on every read accepted while busy. After the erase it stays at the value left by the last busy read.
- R7: Write cycles accepted while busy are ignored, including a complete command sequence. A sequence started during busy and finished afterwards does not erase.
- R8: After a passing erase the block returns to read-array mode and every location reads FFh.
- R9: With `force_fail` high, the erase ends with status held as bit 7 = 1, bit 5 = 1 and bits 4..0 = 0. The array then holds 00h everywhere, left by the pre-program pass.
- R10: In the held-failure state any write cycle clears the hold without being counted as a command cycle. Later reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one clock per cycle |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| force_fail | input | 1 | Test input that makes every erase verify fail |
| rd_data | output | 8 | Registered read data or status byte |

## Verification
Random sequences with one corrupted cycle, in address or data and at any of the six positions, must leave the array readable and untouched, which separates a correct abort from a lost one. A wrong confirm byte tests the setup/confirm pairing on its own. Full sequences with `force_fail` low and then high tell the passing and failing controller paths apart by the exact busy length, by the final array contents (FFh against 00h) and by the held status. Commands written during busy, or split across its end, show whether the lockout actually discards writes.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;

  localparam int CMD_LEN = 6;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
  } cyc_t;

  localparam int ST_DONE = 7;
  localparam int ST_TOG  = 6;
  localparam int ST_FAIL = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_ERASE} phase_t;

  function automatic cyc_t expected_cycle(input logic [2:0] step);
    cyc_t c;
    case (step)
      3'd0, 3'd3: c = '{addr: 16'h5555, data: 8'hAA};
      3'd1, 3'd4: c = '{addr: 16'h2AAA, data: 8'h55};
      3'd2:       c = '{addr: 16'h5555, data: 8'h80};
      default:    c = '{addr: 16'h5555, data: 8'h10};
    endcase
    return c;
  endfunction

  function automatic logic [7:0] preset_byte(input int idx);
    return 8'((idx * 59 + 17) % 256);
  endfunction

endpackage

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import chip_erase_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  output logic              start
);

  logic [2:0] step_q, step_n;
  cyc_t       exp_c;
  logic       hit;

  always_comb begin
    exp_c = expected_cycle(step_q);
    hit   = (wr_addr == ADDR_W'(exp_c.addr)) && (wr_data == exp_c.data);
  end

  always_comb begin
    step_n = step_q;
    start  = 1'b0;
    if (lock) begin
      step_n = 3'd0;
    end else if (wr_en) begin
      if (!hit) begin
        step_n = 3'd0;
      end else if (step_q == 3'(CMD_LEN - 1)) begin
        step_n = 3'd0;
        start  = 1'b1;
      end else begin
        step_n = step_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 3'd0;
    else        step_q <= step_n;
  end

  // R3
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock && !hit) |=> (step_q == 3'd0));

  // R7
  lock_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (step_q == 3'd0));

endmodule

// File: rtl/chip_erase_engine.sv
module chip_erase_engine
  import chip_erase_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 20,
  parameter int MAX_ITER     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               force_fail,
  input  logic               clr_fail,
  output logic               busy,
  output logic               fail,
  output logic [DEPTH*8-1:0] mem_flat
);

  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CMAX   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int ITER_W = $clog2(MAX_ITER + 1);

  phase_t             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [IDX_W-1:0]   loc_q, loc_n;
  logic [ITER_W-1:0]  iter_q, iter_n;
  logic               fail_q, fail_n;
  logic [7:0]         mem_q [DEPTH];
  logic [7:0]         mem_n [DEPTH];

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    loc_n   = loc_q;
    iter_n  = iter_q;
    fail_n  = fail_q;
    mem_n   = mem_q;
    if (clr_fail) fail_n = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_PROG;
          cnt_n   = '0;
          loc_n   = '0;
          iter_n  = '0;
          fail_n  = 1'b0;
        end
      end
      PH_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
          cnt_n        = '0;
          mem_n[loc_q] = 8'h00;
          if (loc_q == IDX_W'(DEPTH - 1)) begin
            phase_n = PH_ERASE;
            loc_n   = '0;
          end else begin
            loc_n = loc_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_ERASE: begin
        if (cnt_q == CNT_W'(ERASE_CYCLES - 1)) begin
          cnt_n = '0;
          if (!force_fail) begin
            for (int i = 0; i < DEPTH; i++) mem_n[i] = 8'hFF;
            phase_n = PH_IDLE;
            iter_n  = '0;
          end else if (iter_q == ITER_W'(MAX_ITER - 1)) begin
            fail_n  = 1'b1;
            phase_n = PH_IDLE;
            iter_n  = '0;
          end else begin
            iter_n = iter_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      loc_q   <= '0;
      iter_q  <= '0;
      fail_q  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= preset_byte(i);
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      loc_q   <= loc_n;
      iter_q  <= iter_n;
      fail_q  <= fail_n;
      mem_q   <= mem_n;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign fail = fail_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat[g*8 +: 8] = mem_q[g];
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  busy_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q < ITER_W'(MAX_ITER));

  // R9
  fail_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $fell(busy));

endmodule

// File: rtl/chip_erase_status.sv
module chip_erase_status
  import chip_erase_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               busy,
  input  logic               fail,
  input  logic [DEPTH*8-1:0] mem_flat,
  output logic [7:0]         rd_data
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              tog_q, tog_n;
  logic [7:0]        data_q, data_n;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        status;

  assign idx = rd_addr[IDX_W-1:0];

  always_comb begin
    status          = 8'h00;
    status[ST_DONE] = ~busy;
    status[ST_TOG]  = tog_q;
    status[ST_FAIL] = fail;
  end

  always_comb begin
    tog_n  = tog_q;
    data_n = data_q;
    if (rd_en) begin
      data_n = (busy || fail) ? status : mem_flat[idx*8 +: 8];
      if (busy) tog_n = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      data_q <= 8'h00;
    end else begin
      tog_q  <= tog_n;
      data_q <= data_n;
    end
  end

  assign rd_data = data_q;

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (tog_q != $past(tog_q)));

  // R6
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));

  // R9
  fail_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail && busy));

endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
  import chip_erase_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DEPTH        = 8,
  parameter int PROG_CYCLES  = 3,
  parameter int ERASE_CYCLES = 20,
  parameter int MAX_ITER     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              force_fail,
  output logic [7:0]        rd_data
);

  logic               start;
  logic               busy;
  logic               fail;
  logic               lock;
  logic               clr_fail;
  logic [DEPTH*8-1:0] mem_flat;

  assign lock     = busy | fail;
  assign clr_fail = wr_en & fail;

  chip_erase_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lock    (lock),
    .start   (start)
  );

  chip_erase_engine #(
    .DEPTH        (DEPTH),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .MAX_ITER     (MAX_ITER)
  ) i_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .force_fail (force_fail),
    .clr_fail   (clr_fail),
    .busy       (busy),
    .fail       (fail),
    .mem_flat   (mem_flat)
  );

  chip_erase_status #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .fail     (fail),
    .mem_flat (mem_flat),
    .rd_data  (rd_data)
  );

  // R10
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fail) |=> !fail);

endmodule

// File: tb/test_chip_erase_ctrl.sv
module test_chip_erase_ctrl;

  localparam int ADDR_W = 16;
  localparam int DEPTH  = 8;
  localparam int PROG   = 3;
  localparam int ERASE  = 20;
  localparam int MAXI   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              force_fail;
  logic [7:0]        rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  chip_erase_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_CYCLES(PROG),
    .ERASE_CYCLES(ERASE), .MAX_ITER(MAXI)
  ) i_chip_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .force_fail(force_fail), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 59 + 17) % 256);
  endfunction

  function automatic logic [15:0] cmd_addr(input int k);
    return (k == 1 || k == 4) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] cmd_data(input int k);
    case (k)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h10;
    endcase
  endfunction

  function automatic int busy_len(input bit fl);
    return DEPTH * PROG + (fl ? MAXI : 1) * ERASE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int loc, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ADDR_W'(loc);
    @(posedge clk); #1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic full_cmd();
    for (int k = 0; k < 6; k++) wr(cmd_addr(k), cmd_data(k));
  endtask

  // called right after the sixth write; polls each clock
  task automatic poll(input bit fl, output logic [7:0] last);
    int n = 0;
    logic prev_t = 1'b0;
    bit tog_ok = 1'b1;
    rd_en = 1'b1; rd_addr = ADDR_W'($urandom % DEPTH);
    forever begin
      @(posedge clk); #1;
      if (rd_data[7]) break;
      if (n > 0 && rd_data[6] == prev_t) tog_ok = 1'b0;
      prev_t = rd_data[6];
      n++;
      if (n > 1000) break;
    end
    last = rd_data;
    @(negedge clk); rd_en = 1'b0;
    check(n == busy_len(fl), "R5 busy length", n, busy_len(fl)); // R5
    check(tog_ok, "R6 toggle alternates", tog_ok, 1);            // R6
    if (fl) check(last[6] == ~prev_t, "R6 toggle after end", last[6], ~prev_t);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v, v2, last;
    void'($urandom(32'h5EED1));
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0;
    rd_en = 0; rd_addr = '0; force_fail = 0;
    #12;
    check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check(v == pat(i), "R1 preset read", v, pat(i));
    end

    // R3 random corrupted sequences
    for (int t = 0; t < 16; t++) begin
      int pos = $urandom % 6;
      int loc = $urandom % DEPTH;
      for (int k = 0; k < 6; k++) begin
        logic [15:0] a = cmd_addr(k);
        logic [7:0]  d = cmd_data(k);
        if (k == pos) begin
          if ($urandom % 2) d = d ^ 8'(1 + $urandom % 255);
          else              a = a ^ 16'(1 + $urandom % 65535);
        end
        wr(a, d);
      end
      rd(loc, v);
      check(v == pat(loc), "R3 abort keeps array", v, pat(loc));
    end

    // R4 wrong confirm byte
    for (int k = 0; k < 5; k++) wr(cmd_addr(k), cmd_data(k));
    wr(16'h5555, 8'h30);
    rd(2, v);
    check(v == pat(2), "R4 wrong confirm aborts", v, pat(2));

    // R2 R5 R6 R8 passing erase
    full_cmd();
    poll(1'b0, last);
    rd(3, v);
    check(v == 8'hFF, "R8 array erased", v, 8'hFF);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check(v == 8'hFF, "R8 all locations FF", v, 8'hFF);
    end

    // R9 forced failure
    force_fail = 1'b1;
    full_cmd();
    poll(1'b1, last);
    check((last & 8'hBF) == 8'hA0, "R9 fail status", last, 8'hA0);
    rd(1, v); rd(4, v2);
    check(v == last && v2 == last, "R9 status held", v2, last);
    force_fail = 1'b0;

    // R10 clearing write, not tracked
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    rd(0, v);
    check(v == 8'h00, "R10 read array after clear", v, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, v);
      check(v == 8'h00, "R9 pre-program left 00", v, 8'h00);
    end
    wr(16'h5555, 8'h10); // would complete a sequence only if clear write counted
    rd(5, v);
    check(v == 8'h00, "R10 clearing write not counted", v, 8'h00);

    // R7 full command during busy ignored
    full_cmd();
    full_cmd();
    rd(6, v);
    check(v[7] == 1'b0, "R2 status during busy", v, 0);
    for (int w = 0; w < 200; w++) @(negedge clk);
    rd(6, v);
    check(v == 8'hFF, "R7 no restart from busy writes", v, 8'hFF);

    // R7 sequence split across the end of busy
    full_cmd();
    for (int k = 0; k < 3; k++) wr(cmd_addr(k), cmd_data(k));
    for (int w = 0; w < 200; w++) @(negedge clk);
    for (int k = 3; k < 6; k++) wr(cmd_addr(k), cmd_data(k));
    rd(7, v);
    check(v == 8'hFF, "R7 split sequence ignored", v, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule